// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block watches the clock and data lines of an I2C bus, after they have been brought into the local clock domain, and recognises the three framing conditions. A START is SDA falling while SCL stays high. A STOP is SDA rising while SCL stays high. A repeated START is a START that arrives while a transfer is already in progress. For each condition it produces a one-clock event pulse that an interrupt controller can latch.

Start events are reported for every START and repeated START, in either role. Stop events are reported for every STOP unless a qualification mode is active. In slave role the block can report only STOPs that close a transfer addressed to its own address; a general call does not count for this. In master role it can report only STOPs that close a transfer in which the master was active, unless ultra-fast mode is selected. Restart events are reported only to an addressed slave that has enabled them. A repeated START that arrives before any address phase, such as after a high-speed master code or a start byte, finds the slave not yet addressed and gives no restart event.

A two-state bus tracker with the states BUS_IDLE and BUS_BUSY does the classification. The transition IDLE_TO_BUSY is taken on a START. The transition BUSY_TO_IDLE is taken on a STOP. The self-loop BUSY_RESTART is taken on a START seen while busy. A STOP seen in BUS_IDLE leaves the state unchanged and is still reported. An event pulse appears in the clock cycle after the third rising edge, counting the edge that first samples the line change as the first.

Top module: `i2c_cond_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, all three event outputs are low. The bus tracker starts in BUS_IDLE, and both synchronized lines start high.
- R2: SDA falling while SCL is high on both the old and the new sample pulses `start_evt` for one cycle. The pulse follows the edge that first samples the SDA change by two clocks, and it is independent of the role and of the configuration.
- R3: A START seen in BUS_BUSY is a repeated START. It pulses `start_evt`, and it does not end the transfer.
- R4: With no qualification mode active, SDA rising while SCL is high pulses `stop_evt` for one cycle in either role. This holds in BUS_IDLE as well.
- R5: In slave role (`role_master`=0) with `cfg_stop_if_addr`=1, `stop_evt` pulses only if own-address match (`slv_addressed`=1 with `gcall_addressed`=0) was seen during the transfer or is present at the STOP. A general-call-only transfer gives no stop event.
- R6: In master role with `cfg_stop_if_mact`=1 and `cfg_ultra_fast`=0, `stop_evt` pulses only if `mst_active` was high during the transfer or at the STOP. With `cfg_ultra_fast`=1, every STOP is reported.
- R7: `restart_evt` pulses together with `start_evt` for a repeated START only when `role_master`=0, `cfg_restart_en`=1 and `slv_addressed`=1. A repeated START that comes before the address phase gives none.
- R8: SDA edges while SCL is low, as in data bits, give no event. No event output is ever high for two cycles in a row, and `start_evt` and `stop_evt` are never high together.
- R9: The transfer record (own-address and master-active seen) is cleared by a START from BUS_IDLE and by a STOP. It is kept across a repeated START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| slv_addressed | input | 1 | Slave is currently addressed (own address or general call) |
| gcall_addressed | input | 1 | Current addressing was by general call |
| mst_active | input | 1 | Master state machine is active |
| role_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_stop_if_addr | input | 1 | Slave: report STOP only for own-address transfers |
| cfg_stop_if_mact | input | 1 | Master: report STOP only when the master was active |
| cfg_ultra_fast | input | 1 | Ultra-fast mode; disables the master STOP qualification |
| cfg_restart_en | input | 1 | Enable restart events |
| start_evt | output | 1 | START or repeated START pulse |
| stop_evt | output | 1 | Qualified STOP pulse |
| restart_evt | output | 1 | Qualified repeated START pulse |

## Verification
A bus tracker left in the wrong state shows first as a `restart_evt` that is missing or extra on the next START, because idle and busy differ only in how a START is classified. A stale or missing transfer record shows only at the next STOP, as a `stop_evt` that disappears or appears under qualification. A synchronizer or edge-history fault moves or drops pulses by whole cycles. The reference model predicts each output on every clock, so these faults are reported in the cycle they first reach a port and not only when a scenario ends.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_BUSY = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic rstart;
        logic stop;
    } raw_cond_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_sync,
    output logic line_prev
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= 1'b1;
        end else begin
            chain_q[0] <= line_in;
        end
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b1;
                end else begin
                    chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= chain_q[LAST];
        end
    end

    assign line_sync = chain_q[LAST];
    assign line_prev = prev_q;

endmodule

// File: rtl/i2c_cond_classify.sv
module i2c_cond_classify
    import i2c_cond_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_s,
    input  logic      scl_p,
    input  logic      sda_s,
    input  logic      sda_p,
    output raw_cond_t raw,
    output logic      bus_busy
);
    bus_state_e state_q, state_d;
    logic       scl_high, sda_fall, sda_rise;

    assign scl_high = scl_s & scl_p;
    assign sda_fall = sda_p & ~sda_s;
    assign sda_rise = ~sda_p & sda_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (scl_high && sda_fall) state_d = BUS_BUSY;
            BUS_BUSY: if (scl_high && sda_rise) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        raw = '0;
        unique case (state_q)
            BUS_IDLE: begin
                raw.start = scl_high & sda_fall;
                raw.stop  = scl_high & sda_rise;
            end
            BUS_BUSY: begin
                raw.rstart = scl_high & sda_fall;
                raw.stop   = scl_high & sda_rise;
            end
            default: raw = '0;
        endcase
    end

    assign bus_busy = (state_q == BUS_BUSY);

endmodule

// File: rtl/i2c_event_qualify.sv
module i2c_event_qualify
    import i2c_cond_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  raw_cond_t raw,
    input  logic      slv_addressed,
    input  logic      gcall_addressed,
    input  logic      mst_active,
    input  logic      role_master,
    input  logic      cfg_stop_if_addr,
    input  logic      cfg_stop_if_mact,
    input  logic      cfg_ultra_fast,
    input  logic      cfg_restart_en,
    output logic      start_evt,
    output logic      stop_evt,
    output logic      restart_evt
);
    logic own_hit;
    logic addr_q, mact_q;
    logic stop_ok, rstart_ok;

    assign own_hit = slv_addressed & ~gcall_addressed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= 1'b0;
            mact_q <= 1'b0;
        end else if (raw.start || raw.stop) begin
            addr_q <= 1'b0;
            mact_q <= 1'b0;
        end else begin
            if (own_hit)    addr_q <= 1'b1;
            if (mst_active) mact_q <= 1'b1;
        end
    end

    always_comb begin
        if (!role_master && cfg_stop_if_addr) begin
            stop_ok = addr_q | own_hit;
        end else if (role_master && cfg_stop_if_mact && !cfg_ultra_fast) begin
            stop_ok = mact_q | mst_active;
        end else begin
            stop_ok = 1'b1;
        end
    end

    assign rstart_ok = ~role_master & cfg_restart_en & slv_addressed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_evt   <= 1'b0;
            stop_evt    <= 1'b0;
            restart_evt <= 1'b0;
        end else begin
            start_evt   <= raw.start | raw.rstart;
            stop_evt    <= raw.stop & stop_ok;
            restart_evt <= raw.rstart & rstart_ok;
        end
    end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_cond_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic slv_addressed,
    input  logic gcall_addressed,
    input  logic mst_active,
    input  logic role_master,
    input  logic cfg_stop_if_addr,
    input  logic cfg_stop_if_mact,
    input  logic cfg_ultra_fast,
    input  logic cfg_restart_en,
    output logic start_evt,
    output logic stop_evt,
    output logic restart_evt
);
    logic      scl_s, scl_p, sda_s, sda_p;
    raw_cond_t raw;
    logic      bus_busy;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in),
        .line_sync(scl_s), .line_prev(scl_p)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in),
        .line_sync(sda_s), .line_prev(sda_p)
    );

    i2c_cond_classify u_class (
        .clk(clk), .rst_n(rst_n),
        .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
        .raw(raw), .bus_busy(bus_busy)
    );

    i2c_event_qualify u_qual (
        .clk(clk), .rst_n(rst_n), .raw(raw),
        .slv_addressed(slv_addressed), .gcall_addressed(gcall_addressed),
        .mst_active(mst_active), .role_master(role_master),
        .cfg_stop_if_addr(cfg_stop_if_addr), .cfg_stop_if_mact(cfg_stop_if_mact),
        .cfg_ultra_fast(cfg_ultra_fast), .cfg_restart_en(cfg_restart_en),
        .start_evt(start_evt), .stop_evt(stop_evt), .restart_evt(restart_evt)
    );

endmodule

// File: rtl/i2c_cond_detect_chk.sv
module i2c_cond_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic slv_addressed,
    input logic gcall_addressed,
    input logic mst_active,
    input logic role_master,
    input logic cfg_stop_if_addr,
    input logic cfg_stop_if_mact,
    input logic cfg_ultra_fast,
    input logic cfg_restart_en,
    input logic start_evt,
    input logic stop_evt,
    input logic restart_evt,
    input logic addr_seen,
    input logic mact_seen
);
    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !start_evt);

    a_r8_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !stop_evt);

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_evt && stop_evt));

    a_r3_restart_is_start: assert property (@(posedge clk) disable iff (!rst_n)
        restart_evt |-> start_evt);

    a_r7_restart_gate: assert property (@(posedge clk) disable iff (!rst_n)
        restart_evt |-> $past(!role_master && cfg_restart_en && slv_addressed));

    a_r5_slave_stop_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && $past(!role_master && cfg_stop_if_addr))
        |-> $past(addr_seen || (slv_addressed && !gcall_addressed)));

    a_r6_master_stop_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && $past(role_master && cfg_stop_if_mact && !cfg_ultra_fast))
        |-> $past(mact_seen || mst_active));

endmodule

bind i2c_cond_detect i2c_cond_detect_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .slv_addressed(slv_addressed), .gcall_addressed(gcall_addressed),
    .mst_active(mst_active), .role_master(role_master),
    .cfg_stop_if_addr(cfg_stop_if_addr), .cfg_stop_if_mact(cfg_stop_if_mact),
    .cfg_ultra_fast(cfg_ultra_fast), .cfg_restart_en(cfg_restart_en),
    .start_evt(start_evt), .stop_evt(stop_evt), .restart_evt(restart_evt),
    .addr_seen(u_qual.addr_q), .mact_seen(u_qual.mact_q)
);

// File: tb/i2c_cond_detect_test.sv
module i2c_cond_detect_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic slv_addressed = 1'b0, gcall_addressed = 1'b0, mst_active = 1'b0;
    logic role_master = 1'b0;
    logic cfg_stop_if_addr = 1'b0, cfg_stop_if_mact = 1'b0;
    logic cfg_ultra_fast = 1'b0, cfg_restart_en = 1'b0;
    logic start_evt, stop_evt, restart_evt;

    int n_tests = 0, n_fail = 0, cycles = 0;
    int c_start = 0, c_stop = 0, c_rs = 0;
    string cur_req = "R1";
    bit finished = 0;

    always #2.5 clk = ~clk;

    i2c_cond_detect uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .slv_addressed(slv_addressed), .gcall_addressed(gcall_addressed),
        .mst_active(mst_active), .role_master(role_master),
        .cfg_stop_if_addr(cfg_stop_if_addr), .cfg_stop_if_mact(cfg_stop_if_mact),
        .cfg_ultra_fast(cfg_ultra_fast), .cfg_restart_en(cfg_restart_en),
        .start_evt(start_evt), .stop_evt(stop_evt), .restart_evt(restart_evt)
    );

    // Behavioural reference: line history queues and transfer flags
    int  hscl[$], hsda[$];
    bit  m_busy, m_addr, m_mact;
    bit  e_start, e_stop, e_rs;

    always @(posedge clk) begin
        if (!rst_n) begin
            hscl = '{1, 1, 1};
            hsda = '{1, 1, 1};
            m_busy = 0; m_addr = 0; m_mact = 0;
            e_start = 0; e_stop = 0; e_rs = 0;
        end else begin
            bit hi, fall, rise, own, ok;
            hi   = (hscl[1] == 1) && (hscl[2] == 1);
            fall = hi && hsda[2] == 1 && hsda[1] == 0;
            rise = hi && hsda[2] == 0 && hsda[1] == 1;
            own  = slv_addressed && !gcall_addressed;
            if (!role_master && cfg_stop_if_addr)                     ok = m_addr || own;
            else if (role_master && cfg_stop_if_mact && !cfg_ultra_fast) ok = m_mact || mst_active;
            else                                                        ok = 1;
            e_start = fall;
            e_stop  = rise && ok;
            e_rs    = fall && m_busy && !role_master && cfg_restart_en && slv_addressed;
            if ((fall && !m_busy) || rise) begin
                m_addr = 0; m_mact = 0;
            end else begin
                if (own) m_addr = 1;
                if (mst_active) m_mact = 1;
            end
            if (fall) m_busy = 1;
            if (rise) m_busy = 0;
            hscl.push_front(int'(scl_in)); void'(hscl.pop_back());
            hsda.push_front(int'(sda_in)); void'(hsda.pop_back());
        end
    end

    task automatic check1(string req, string what, logic got, logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b at cycle %0d", req, what, got, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !finished) begin
            check1(cur_req, "start_evt", start_evt, e_start);
            check1(cur_req, "stop_evt", stop_evt, e_stop);
            check1(cur_req, "restart_evt", restart_evt, e_rs);
            c_start += int'(start_evt);
            c_stop  += int'(stop_evt);
            c_rs    += int'(restart_evt);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clr();
        c_start = 0; c_stop = 0; c_rs = 0;
    endtask

    task automatic check_cnt(string req, string what, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s count: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic b_start();
        scl_in = 1; sda_in = 1; tick(4);
        sda_in = 0; tick(4);
        scl_in = 0; tick(3);
    endtask

    task automatic b_rstart();
        scl_in = 0; sda_in = 1; tick(3);
        scl_in = 1; tick(4);
        sda_in = 0; tick(4);
        scl_in = 0; tick(3);
    endtask

    task automatic b_stop();
        scl_in = 0; sda_in = 0; tick(3);
        scl_in = 1; tick(4);
        sda_in = 1; tick(6);
    endtask

    task automatic b_bit(bit b);
        scl_in = 0; sda_in = b; tick(2);
        scl_in = 1; tick(3);
        scl_in = 0; tick(2);
    endtask

    task automatic b_byte(int v);
        for (int i = 7; i >= 0; i--) b_bit(v[i]);
        b_bit(0);
    endtask

    initial begin
        tick(4);
        check1("R1", "start_evt in reset", start_evt, 1'b0);
        check1("R1", "stop_evt in reset", stop_evt, 1'b0);
        check1("R1", "restart_evt in reset", restart_evt, 1'b0);
        rst_n = 1; tick(3);

        // R2, R4, R8: plain slave transfer, default configuration
        cur_req = "R2"; clr();
        b_start(); tick(1);
        check_cnt("R2", "start", c_start, 1);
        cur_req = "R8"; clr();
        b_byte(8'hA5); b_byte(8'h3C);
        check_cnt("R8", "events during data", c_start + c_stop + c_rs, 0);
        cur_req = "R4"; clr();
        b_stop();
        check_cnt("R4", "stop", c_stop, 1);

        // R4 in master role, and a STOP while idle
        role_master = 1; clr();
        b_start(); b_byte(8'h12); b_stop();
        scl_in = 0; tick(2); b_stop();
        check_cnt("R4", "master and idle stops", c_stop, 2);
        role_master = 0;

        // R3, R7: addressed slave, restart enabled
        cur_req = "R7"; cfg_restart_en = 1; clr();
        b_start(); slv_addressed = 1; b_byte(8'h50);
        b_rstart(); b_byte(8'h51); b_stop(); slv_addressed = 0;
        check_cnt("R3", "start incl restart", c_start, 2);
        check_cnt("R7", "restart addressed", c_rs, 1);

        // R7: repeated START before any address phase
        clr();
        b_start(); b_byte(8'h08); b_rstart(); slv_addressed = 1;
        b_byte(8'h50); b_stop(); slv_addressed = 0;
        check_cnt("R7", "restart before address", c_rs, 0);

        // R7: disabled enable, and master role, both addressed
        clr(); cfg_restart_en = 0;
        b_start(); slv_addressed = 1; b_rstart(); b_stop();
        cfg_restart_en = 1; role_master = 1;
        b_start(); b_rstart(); b_stop(); slv_addressed = 0; role_master = 0;
        check_cnt("R7", "restart gated", c_rs, 0);
        check_cnt("R3", "starts gated case", c_start, 4);

        // R5, R9: slave STOP only when own address matched
        cur_req = "R5"; cfg_stop_if_addr = 1; clr();
        b_start(); slv_addressed = 1; tick(2); slv_addressed = 0;
        b_byte(8'h77); b_stop();
        check_cnt("R5", "own addressed stop", c_stop, 1);
        clr();
        b_start(); slv_addressed = 1; gcall_addressed = 1; b_byte(8'h00);
        b_stop(); slv_addressed = 0; gcall_addressed = 0;
        check_cnt("R5", "general call stop", c_stop, 0);
        cur_req = "R9"; clr();
        b_start(); b_byte(8'h44); b_stop();
        check_cnt("R9", "record cleared, unaddressed stop", c_stop, 0);
        clr();
        b_start(); slv_addressed = 1; tick(2); slv_addressed = 0;
        b_rstart(); b_byte(8'h10); b_stop();
        check_cnt("R9", "record kept over restart", c_stop, 1);
        cfg_stop_if_addr = 0;

        // R6: master STOP only when master active, ultra-fast override
        cur_req = "R6"; role_master = 1; cfg_stop_if_mact = 1; clr();
        b_start(); mst_active = 1; tick(2); mst_active = 0; b_byte(8'h21); b_stop();
        check_cnt("R6", "active master stop", c_stop, 1);
        clr();
        b_start(); b_byte(8'h22); b_stop();
        check_cnt("R6", "inactive master stop", c_stop, 0);
        clr(); cfg_ultra_fast = 1;
        b_start(); b_byte(8'h23); b_stop();
        check_cnt("R6", "ultra-fast stop", c_stop, 1);
        cfg_ultra_fast = 0; cfg_stop_if_mact = 0; role_master = 0;

        tick(4);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule